// File: doc/BRIEF.md
# Periodic Down-Counter Timer

A 32-bit down-counting timer that sits on a simple word-addressed register bus. A prescaled tick, picked from one of three tick-enable inputs, decrements the counter by one. When the counter passes zero it either reloads from a programmable load value or wraps to all-ones. When a tick brings the counter onto the compare value, a sticky match flag is set. That flag, gated by an interrupt enable and the timer enable, drives a level interrupt.

Software programs the control word, the load value and the compare value, and polls or clears the match flag. The counter itself can be read at any time. Two options control how the count is seeded: when the timer is enabled with the seed option set, the counter starts from a known value; when the overwrite option is set, writing the load value puts that value into the counter at once. A software-reset bit returns the block to its reset state, except for a small set of enable bits that it keeps.

Top module: `prd_timer`

## Requirements
- R1: Word offset 0 selects control, 1 status, 2 load, 3 compare and 4 the counter, which is read-only. Reads of offsets 5 to 7 return zero. Writes to offsets 4 to 7 change nothing.
- R2: A control write stores only bits 25:0. Bits 31:26 of the control register always read back as zero. Bit map: enable 0, seed-on-enable 1, interrupt enable 2, reload mode 3, prescale 15:4, software reset 16, overwrite 17, and held-only bits 18, 19, 20 and 21; clock source 25:24.
- R3: irq_o is high exactly when the match flag (status bit 0), the interrupt enable and the timer enable are all set.
- R4: A status write with bit 0 set clears the match flag. A status write with bit 0 clear leaves the flag unchanged.
- R5: A tick whose resulting counter value equals the compare value sets the match flag, whatever the interrupt enable is. No tick, and so no match, occurs while the timer enable is clear. If a match and a clearing write land in the same cycle, the match wins.
- R6: Clock source 00 gives no ticks, 01 takes tick_per_i, 10 takes tick_hf_i and 11 takes tick_lf_i. A prescale of P turns every P+1 selected pulses into one counter tick. The divider restarts while the timer is disabled.
- R7: A control write with bit 16 set stores only bits 0, 1, 18, 19, 20 and 21 of the written value. Bit 16 itself reads back as zero.
- R8: Both hard reset and software reset clear the status and compare registers, set the load register to 0xFFFFFFFF and set the counter to 0xFFFFFFFF. Hard reset also clears the whole control register. Because the clock source ends up as 00, the counter then holds its value.
- R9: A tick at counter value zero loads the load value if reload mode is set, and 0xFFFFFFFF if it is clear. Any other tick decrements the counter by one.
- R10: A control write that takes enable from 0 to 1 with the seed bit set loads the counter with the load value (reload mode) or with 0xFFFFFFFF (free-running mode). Without the seed bit, the counter resumes from the value it held.
- R11: A load write while the overwrite bit is set also puts the written value into the counter in the same cycle.
- R12: The counter changes by at most one step for each tick. A write that sets the counter wins over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hard reset |
| addr_i | input | 3 | Word offset |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| tick_per_i | input | 1 | Peripheral-clock tick enable |
| tick_hf_i | input | 1 | High-frequency tick enable |
| tick_lf_i | input | 1 | Low-frequency tick enable |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that each tick enable is a one-cycle pulse sampled at the clock edge, and that we_i is held for one cycle per access, with addr_i and wdata_i stable during that cycle. They also assume that all inputs are known from the first edge after reset. The bench drives each access and each tick pulse on the falling edge for exactly one cycle. It drives ticks one at a time, except in the same-cycle collision case, so every counter step can be predicted exactly.

// File: rtl/prd_timer_pkg.sv
package prd_timer_pkg;
  localparam int unsigned DW   = 32;
  localparam int unsigned AW   = 3;
  localparam int unsigned PSW  = 12;
  localparam int unsigned CTLW = 26;
  localparam int unsigned NSRC = 3;

  localparam logic [AW-1:0] OFF_CTRL = 3'd0;
  localparam logic [AW-1:0] OFF_STAT = 3'd1;
  localparam logic [AW-1:0] OFF_LOAD = 3'd2;
  localparam logic [AW-1:0] OFF_CMP  = 3'd3;
  localparam logic [AW-1:0] OFF_CNT  = 3'd4;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_PER  = 2'b01,
    SRC_HF   = 2'b10,
    SRC_LF   = 2'b11
  } clk_src_e;

  typedef struct packed {
    clk_src_e       src;
    logic [1:0]     spare;
    logic           stop_en;
    logic           doze_en;
    logic           wait_en;
    logic           dbg_en;
    logic           ovw;
    logic           sw_rst;
    logic [PSW-1:0] presc;
    logic           rld;
    logic           irq_en;
    logic           seed;
    logic           en;
  } ctrl_t;

  // bits surviving a software reset: en, seed, dbg, wait, doze, stop
  localparam logic [CTLW-1:0] SWR_KEEP = 26'h03C_0003;
endpackage

// File: rtl/prd_timer_presc.sv
module prd_timer_presc
  import prd_timer_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  clk_src_e        src_i,
  input  logic [PSW-1:0]  presc_i,
  input  logic [NSRC-1:0] ticks_i,
  output logic            tick_o
);
  logic           sel;
  logic [PSW-1:0] div_q;
  logic           run;

  always_comb begin
    unique case (src_i)
      SRC_PER: sel = ticks_i[0];
      SRC_HF:  sel = ticks_i[1];
      SRC_LF:  sel = ticks_i[2];
      default: sel = 1'b0;
    endcase
  end

  assign run    = en_i && (src_i != SRC_NONE);
  assign tick_o = run && sel && (div_q == presc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 div_q <= '0;
    else if (!run)               div_q <= '0;
    else if (tick_o)             div_q <= '0;
    else if (sel)                div_q <= div_q + 1'b1;
  end

  // R6
  src_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_NONE) |-> !tick_o);

  // R6
  div_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> (div_q <= presc_i));
endmodule

// File: rtl/prd_timer_cnt.sv
module prd_timer_cnt
  import prd_timer_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rld_i,
  input  logic [DW-1:0] load_i,
  input  logic [DW-1:0] cmp_i,
  input  logic          set_i,
  input  logic [DW-1:0] set_val_i,
  output logic [DW-1:0] cnt_o,
  output logic          match_o
);
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] step;

  assign step    = (cnt_q == '0) ? (rld_i ? load_i : '1) : cnt_q - 1'b1;
  assign match_o = tick_i && !set_i && (step == cmp_i);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '1;
    else if (set_i)   cnt_q <= set_val_i;
    else if (tick_i)  cnt_q <= step;
  end

  // R12
  cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !set_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R12
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !set_i) |=> $stable(cnt_q));

  // R9
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !set_i && cnt_q == '0 && !rld_i) |=> (cnt_q == '1));

  // R9
  cnt_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !set_i && cnt_q == '0 && rld_i) |=> (cnt_q == $past(load_i)));
endmodule

// File: rtl/prd_timer_regs.sv
module prd_timer_regs
  import prd_timer_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          match_i,
  output ctrl_t         ctrl_o,
  output logic          flag_o,
  output logic [DW-1:0] load_o,
  output logic [DW-1:0] cmp_o,
  output logic          set_o,
  output logic [DW-1:0] set_val_o
);
  ctrl_t         ctrl_q, ctrl_new;
  logic          flag_q;
  logic [DW-1:0] load_q, cmp_q;
  logic          wr_ctrl, wr_stat, wr_load, wr_cmp;
  logic          soft_rst, en_seed, ovw_load;

  assign wr_ctrl  = we_i && (addr_i == OFF_CTRL);
  assign wr_stat  = we_i && (addr_i == OFF_STAT);
  assign wr_load  = we_i && (addr_i == OFF_LOAD);
  assign wr_cmp   = we_i && (addr_i == OFF_CMP);
  assign ctrl_new = ctrl_t'(wdata_i[CTLW-1:0]);

  assign soft_rst = wr_ctrl && ctrl_new.sw_rst;
  assign en_seed  = wr_ctrl && !ctrl_q.en && ctrl_new.en && ctrl_new.seed;
  assign ovw_load = wr_load && ctrl_q.ovw;

  assign set_o = soft_rst || en_seed || ovw_load;

  always_comb begin
    if (soft_rst)      set_val_o = '1;
    else if (ovw_load) set_val_o = wdata_i;
    else               set_val_o = ctrl_new.rld ? load_q : '1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      load_q <= '1;
      cmp_q  <= '0;
    end else if (soft_rst) begin
      ctrl_q <= ctrl_t'(wdata_i[CTLW-1:0] & SWR_KEEP);
      load_q <= '1;
      cmp_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_new;
      if (wr_load) load_q <= wdata_i;
      if (wr_cmp)  cmp_q  <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     flag_q <= 1'b0;
    else if (soft_rst)               flag_q <= 1'b0;
    else if (match_i)                flag_q <= 1'b1;
    else if (wr_stat && wdata_i[0])  flag_q <= 1'b0;
  end

  assign ctrl_o = ctrl_q;
  assign flag_o = flag_q;
  assign load_o = load_q;
  assign cmp_o  = cmp_q;

  // R5
  match_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |-> ctrl_q.en);

  // R5
  flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(match_i));

  // R7
  swr_self_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.sw_rst);

  // R8
  swr_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (load_q == '1 && cmp_q == '0 && !flag_q && ctrl_q.src == SRC_NONE));
endmodule

// File: rtl/prd_timer.sv
module prd_timer
  import prd_timer_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          tick_per_i,
  input  logic          tick_hf_i,
  input  logic          tick_lf_i,
  output logic          irq_o
);
  ctrl_t         ctrl;
  logic          flag, match, tick, cnt_set;
  logic [DW-1:0] load, cmp, cnt, cnt_set_val;

  prd_timer_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .we_i      (we_i),
    .wdata_i   (wdata_i),
    .match_i   (match),
    .ctrl_o    (ctrl),
    .flag_o    (flag),
    .load_o    (load),
    .cmp_o     (cmp),
    .set_o     (cnt_set),
    .set_val_o (cnt_set_val)
  );

  prd_timer_presc u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ctrl.en),
    .src_i   (ctrl.src),
    .presc_i (ctrl.presc),
    .ticks_i ({tick_lf_i, tick_hf_i, tick_per_i}),
    .tick_o  (tick)
  );

  prd_timer_cnt u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .rld_i     (ctrl.rld),
    .load_i    (load),
    .cmp_i     (cmp),
    .set_i     (cnt_set),
    .set_val_i (cnt_set_val),
    .cnt_o     (cnt),
    .match_o   (match)
  );

  always_comb begin
    unique case (addr_i)
      OFF_CTRL: rdata_o = {{(DW-CTLW){1'b0}}, ctrl};
      OFF_STAT: rdata_o = {{(DW-1){1'b0}}, flag};
      OFF_LOAD: rdata_o = load;
      OFF_CMP:  rdata_o = cmp;
      OFF_CNT:  rdata_o = cnt;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = flag && ctrl.irq_en && ctrl.en;

  // R2
  ctrl_hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFF_CTRL) |-> (rdata_o[DW-1:CTLW] == '0));

  // R1
  hole_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i > OFF_CNT) |-> (rdata_o == '0));

  // R3
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFF_STAT && wdata_i[0] && !match) |=> !irq_o);

  // R3
  irq_needs_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(match) || $past(we_i && addr_i == OFF_CTRL)));
endmodule

// File: tb/sim_prd_timer.sv
module sim_prd_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        t_per = 1'b0, t_hf = 1'b0, t_lf = 1'b0;
  logic        irq;
  int          n_chk = 0, n_fail = 0;

  localparam logic [31:0] EN = 32'h1, SEED = 32'h2, IEN = 32'h4, RLD = 32'h8;
  localparam logic [31:0] SWR = 32'h1_0000, OVW = 32'h2_0000;
  localparam logic [31:0] DBG = 32'h4_0000, STP = 32'h20_0000;
  localparam logic [31:0] S_PER = 32'h100_0000, S_HF = 32'h200_0000;

  always #5 clk = ~clk;

  prd_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .tick_per_i(t_per), .tick_hf_i(t_hf), .tick_lf_i(t_lf),
    .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0; addr = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic tk(input int src);
    @(negedge clk);
    t_per = (src == 0); t_hf = (src == 1); t_lf = (src == 2);
    @(negedge clk); t_per = 0; t_hf = 0; t_lf = 0;
  endtask

  task automatic rchk(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    rchk("R8 ctrl", 0, 0);
    rchk("R8 stat", 1, 0);
    rchk("R8 load", 2, 32'hFFFF_FFFF);
    rchk("R8 cmp", 3, 0);
    rchk("R8 cnt", 4, 32'hFFFF_FFFF);
    chk("R3 irq reset", {31'b0, irq}, 0);
  endtask

  task automatic t_ctrl_width;
    wr(0, 32'hFFFE_FFFF);
    rchk("R2 upper zero", 0, 32'h03FE_FFFF);
    wr(0, 0);
  endtask

  task automatic t_reload;
    wr(2, 5);
    wr(0, EN | SEED | RLD | S_PER);
    rchk("R10 seed reload", 4, 5);
    for (int i = 0; i < 5; i++) tk(0);
    rchk("R9 reach zero", 4, 0);
    tk(0);
    rchk("R9 reload", 4, 5);
    wr(0, 0);
  endtask

  task automatic t_wrap;
    wr(0, EN | OVW | S_PER);
    wr(2, 1);
    rchk("R11 overwrite", 4, 1);
    tk(0);
    tk(0);
    rchk("R9 wrap", 4, 32'hFFFF_FFFF);
    tk(0);
    rchk("R9 decrement", 4, 32'hFFFF_FFFE);
    wr(0, S_PER);
    wr(0, EN | S_PER);
    rchk("R10 resume", 4, 32'hFFFF_FFFE);
    wr(0, EN | SEED | S_PER);
    rchk("R10 no rise", 4, 32'hFFFF_FFFE);
    wr(0, 0);
    wr(0, EN | SEED | S_PER);
    rchk("R10 seed free", 4, 32'hFFFF_FFFF);
    wr(0, 0);
  endtask

  task automatic t_presc;
    wr(0, EN | SEED | S_PER | (32'd2 << 4));
    tk(0); tk(0);
    rchk("R6 presc hold", 4, 32'hFFFF_FFFF);
    tk(0);
    rchk("R6 presc step", 4, 32'hFFFF_FFFE);
    tk(1); tk(2);
    tk(1); tk(2);
    tk(1); tk(2);
    rchk("R6 unselected", 4, 32'hFFFF_FFFE);
    wr(0, EN | S_HF);
    tk(1);
    rchk("R6 hf source", 4, 32'hFFFF_FFFD);
    wr(0, EN);
    tk(0); tk(1); tk(2);
    rchk("R6 none", 4, 32'hFFFF_FFFD);
    wr(0, 0);
  endtask

  task automatic t_compare;
    wr(1, 1);
    wr(3, 3);
    wr(2, 5);
    wr(0, EN | SEED | RLD | S_PER);
    tk(0);
    rchk("R5 no match", 1, 0);
    tk(0);
    rchk("R5 match", 1, 1);
    chk("R3 irq off w/o enable", {31'b0, irq}, 0);
    wr(0, EN | IEN | RLD | S_PER);
    @(negedge clk);
    chk("R3 irq on", {31'b0, irq}, 1);
    wr(1, 0);
    rchk("R4 zero write", 1, 1);
    wr(0, IEN | RLD | S_PER);
    @(negedge clk);
    chk("R3 irq gated", {31'b0, irq}, 0);
    wr(1, 1);
    rchk("R4 clear", 1, 0);
    tk(0); tk(0); tk(0);
    rchk("R5 disabled", 1, 0);
    rchk("R5 disabled cnt", 4, 3);
    wr(0, 0);
  endtask

  task automatic t_soft_rst;
    wr(3, 7);
    wr(2, 9);
    wr(0, EN | SEED | IEN | RLD | DBG | STP | S_PER | SWR);
    rchk("R7 kept bits", 0, 32'h0024_0003);
    rchk("R8 soft stat", 1, 0);
    rchk("R8 soft load", 2, 32'hFFFF_FFFF);
    rchk("R8 soft cmp", 3, 0);
    rchk("R8 soft cnt", 4, 32'hFFFF_FFFF);
    tk(0); tk(1); tk(2);
    rchk("R8 stopped", 4, 32'hFFFF_FFFF);
    wr(0, 0);
  endtask

  task automatic t_holes;
    wr(4, 32'h1234);
    rchk("R1 cnt ro", 4, 32'hFFFF_FFFF);
    wr(6, 32'hABCD);
    rchk("R1 hole ctrl", 0, 0);
    rchk("R1 hole load", 2, 32'hFFFF_FFFF);
    rchk("R1 hole cmp", 3, 0);
    rchk("R1 read 5", 5, 0);
    rchk("R1 read 7", 7, 0);
  endtask

  task automatic t_collide;
    wr(0, EN | OVW | S_PER);
    @(negedge clk); addr = 2; wdata = 32'h40; we = 1'b1; t_per = 1'b1;
    @(negedge clk); we = 1'b0; t_per = 1'b0; addr = '0;
    rchk("R12 write wins", 4, 32'h40);
    tk(0);
    rchk("R12 one step", 4, 32'h3F);
    wr(0, 0);
  endtask

  initial begin : wd
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl_width();
    t_reload();
    t_wrap();
    t_presc();
    t_compare();
    t_soft_rst();
    t_holes();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule